// File: doc/BRIEF.md
# Row/Column Strobe DRAM Controller with Refresh

This block sits between a simple synchronous request port and an asynchronous dynamic memory whose address pins are shared between row and column. A request carries a 14-bit word address, a read/write flag and write data, and it is taken with a valid/ready handshake. The controller opens the row with the row strobe, switches the shared address pins to the column and pulses the column strobe. Reads come back on a one-cycle valid pulse. All timing is counted in clock cycles set by module parameters. The defaults suit an 8 ns clock, with every minimum rounded up.

A row stays open after an access. A later request to the same row is served by cycling only the column strobe (page mode). A request to another row closes the open row, waits out the precharge and then opens the new row. A refresh timer raises a pending refresh once per refresh interval, 1/128 of the 2 ms retention period. A pending refresh stops new requests from being taken, closes any open row at the next access boundary and runs a row-only refresh cycle on the next row of a wrapping 7-bit counter. A row-age counter closes an idle or page-busy row early enough that the row strobe never stays low beyond its maximum pulse width.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: During reset and afterwards, until a request or a refresh arrives, mem_rowstb_n, mem_colstb_n and mem_wr_n are high and rsp_valid is low.
- R2: req_addr[13:7] selects the row and is on mem_addr when mem_rowstb_n falls. req_addr[6:0] selects the column and is on mem_addr when mem_colstb_n falls. A read returns the data last written to the same address, or 0 for a cell never written.
- R3: When a row is opened for an access, mem_colstb_n falls exactly T_RAH+1 cycles after mem_rowstb_n falls. mem_colstb_n is never low while mem_rowstb_n is high.
- R4: Every write is an early write. mem_wr_n is low for at least one cycle before mem_colstb_n falls, and it does not change while mem_colstb_n is low.
- R5: For a read, rsp_rdata is mem_din sampled T_CAC cycles after mem_colstb_n falls. rsp_valid is high for exactly one cycle per read.
- R6: A request to the open row is served without a new row strobe fall. Between column strobe pulses of the same row, mem_colstb_n is high for at least T_CP cycles.
- R7: A request to another row closes the open row. mem_rowstb_n then stays high for at least T_RP cycles before it falls again.
- R8: mem_rowstb_n is never low for more than T_RAS_MAX cycles, or for fewer than T_RAS_MIN cycles, in one activation.
- R9: A refresh becomes pending every T_REFI cycles. It is served as a row-only cycle with mem_colstb_n held high, so over any window of W cycles about W/T_REFI refreshes occur.
- R10: Successive refresh cycles present rows that increase by one and wrap from 127 to 0, so all 128 rows are refreshed within 128 refresh intervals.
- R11: While a refresh is pending, req_ready is low and an open row is closed at the next access boundary. A continuous same-row request stream therefore still interleaves refresh cycles and returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this clock edge when req_valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address, row in the upper 7 bits |
| req_wdata | input | 1 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 1 | Read data |
| mem_rowstb_n | output | 1 | Row strobe, active low |
| mem_colstb_n | output | 1 | Column strobe, active low |
| mem_wr_n | output | 1 | Write enable, active low |
| mem_addr | output | 7 | Multiplexed row/column address |
| mem_dout | output | 1 | Data driven to the memory |
| mem_din | input | 1 | Data returned by the memory |

## Verification
The hardest situation to reach from the ports is a refresh tick that lands while a stream of same-row hits keeps the row open, so that the refresh has to break into page mode. A row-age close can also coincide with a page access that has just been taken. The bench shortens the refresh interval and the maximum row pulse through parameters. It then drives a long, gap-free stream of reads to one row, which crosses several refresh ticks and several age limits. A cycle-counting memory model checks every strobe window and the refresh row order throughout.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,   // row closed and precharged
    S_ROW,    // row strobe low, row address held
    S_CADDR,  // column address and write enable set up
    S_COL,    // column strobe low
    S_CPRE,   // column precharge inside an open row
    S_OPEN,   // row open, waiting for the next request
    S_PRE,    // row precharge
    S_REF     // row-only refresh
  } dc_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign done  = (cnt_q == '0);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int T_REFI = 1953,
  parameter int ROW_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_done,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);

  localparam int CW = $clog2(T_REFI);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             tick;

  assign tick = (cnt_q == CW'(T_REFI - 1));

  always_comb begin
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    pend_d = (pend_q && !ref_done) || tick;
    row_d  = ref_done ? row_q + 1'b1 : row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      if (ref_done) row_q <= row_d;
    end
  end

  assign ref_pend = pend_q;
  assign ref_row  = row_q;

  // R9: the previous refresh is served before the next interval ends
  p_no_lost_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (!pend_q || ref_done));

endmodule

// File: rtl/dram_row_age.sv
module dram_row_age #(
  parameter int T_RAS_MAX = 1250,
  parameter int CLOSE_AT  = 1213
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic close_due
);

  localparam int AW = $clog2(T_RAS_MAX + 1);

  logic [AW-1:0] age_q, age_d;

  always_comb begin
    if (!ras_low)
      age_d = '0;
    else if (age_q == AW'(T_RAS_MAX))
      age_d = age_q;
    else
      age_d = age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  assign close_due = (age_q >= AW'(CLOSE_AT));

  // R8: row strobe low run stays within its maximum width
  p_ras_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ras_low |-> (age_q < AW'(T_RAS_MAX)));

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W     = 7,
  parameter int COL_W     = 7,
  parameter int DATA_W    = 1,
  parameter int T_RAH     = 5,
  parameter int T_CAS     = 21,
  parameter int T_CAC     = 21,
  parameter int T_CP      = 13,
  parameter int T_RP      = 19,
  parameter int T_RAS_MIN = 32,
  parameter int T_RAS_MAX = 1250,
  parameter int T_REFI    = 1953
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_write,
  input  logic [ROW_W+COL_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]              req_wdata,
  output logic                           rsp_valid,
  output logic [DATA_W-1:0]              rsp_rdata,
  output logic                           mem_rowstb_n,
  output logic                           mem_colstb_n,
  output logic                           mem_wr_n,
  output logic [imax(ROW_W,COL_W)-1:0]   mem_addr,
  output logic [DATA_W-1:0]              mem_dout,
  input  logic [DATA_W-1:0]              mem_din
);

  localparam int AW        = ROW_W + COL_W;
  localparam int MW        = imax(ROW_W, COL_W);
  localparam int CLOSE_AT  = T_RAS_MAX - T_CAS - T_CP - 3;
  localparam int TMAX      = imax(imax(imax(T_RAH, T_CAS), imax(T_CP, T_RP)), T_RAS_MIN);
  localparam int TW        = $clog2(TMAX + 1);
  localparam int SAMPLE_AT = T_CAS - T_CAC;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  dc_state_e          st_q, st_d;
  logic [ROW_W-1:0]   row_q, row_d;
  logic [COL_W-1:0]   col_q, col_d;
  logic               wr_q, wr_d;
  logic [DATA_W-1:0]  wd_q, wd_d;

  logic               tmr_load, tmr_done;
  logic [TW-1:0]      tmr_val, tmr_cnt;
  logic               ref_pend, ref_done;
  logic [ROW_W-1:0]   ref_row;
  logic               close_due;
  logic               hit, accept;

  logic               ras_n_q, cas_n_q, we_n_q;
  logic [MW-1:0]      addr_q;
  logic [DATA_W-1:0]  dout_q;
  logic               rv_q;
  logic [DATA_W-1:0]  rd_q;

  logic               ras_n_d, cas_n_d, we_n_d;
  logic [MW-1:0]      addr_d;
  logic               rv_d;

  dram_phase_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_cnt),
    .done     (tmr_done)
  );

  dram_refresh_sched #(.T_REFI(T_REFI), .ROW_W(ROW_W)) u_refresh (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ref_done (ref_done),
    .ref_pend (ref_pend),
    .ref_row  (ref_row)
  );

  dram_row_age #(.T_RAS_MAX(T_RAS_MAX), .CLOSE_AT(CLOSE_AT)) u_age (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ras_low   (!ras_n_q),
    .close_due (close_due)
  );

  assign hit = (req_addr[AW-1:COL_W] == row_q);

  assign req_ready = ((st_q == S_IDLE) && !ref_pend) ||
                     ((st_q == S_OPEN) && !ref_pend && !close_due && hit);

  // next-state logic
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_done = 1'b0;
    accept   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (ref_pend) begin
          st_d     = S_REF;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_RAS_MIN - 1);
        end else if (req_valid) begin
          accept   = 1'b1;
          st_d     = S_ROW;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_RAH - 1);
        end
      end
      S_ROW:   if (tmr_done) st_d = S_CADDR;
      S_CADDR: begin
        st_d     = S_COL;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_CAS - 1);
      end
      S_COL: begin
        if (tmr_done) begin
          st_d     = S_CPRE;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_CP - 1);
        end
      end
      S_CPRE:  if (tmr_done) st_d = S_OPEN;
      S_OPEN: begin
        if (ref_pend || close_due || (req_valid && !hit)) begin
          st_d     = S_PRE;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_RP - 1);
        end else if (req_valid) begin
          accept = 1'b1;
          st_d   = S_CADDR;
        end
      end
      S_PRE:   if (tmr_done) st_d = S_IDLE;
      S_REF: begin
        if (tmr_done) begin
          st_d     = S_PRE;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_RP - 1);
          ref_done = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // request fields captured on acceptance
  always_comb begin
    row_d = row_q;
    col_d = col_q;
    wr_d  = wr_q;
    wd_d  = wd_q;
    if (accept) begin
      row_d = req_addr[AW-1:COL_W];
      col_d = req_addr[COL_W-1:0];
      wr_d  = req_write;
      wd_d  = req_wdata;
    end
  end

  // memory pins derived from the next state, then registered
  always_comb begin
    ras_n_d = (st_d == S_IDLE) || (st_d == S_PRE);
    cas_n_d = (st_d != S_COL);
    we_n_d  = !(wr_d && ((st_d == S_CADDR) || (st_d == S_COL)));
    if (st_d == S_REF)
      addr_d = MW'(ref_row);
    else if ((st_d == S_CADDR) || (st_d == S_COL))
      addr_d = MW'(col_d);
    else
      addr_d = MW'(row_d);
    rv_d = (st_q == S_COL) && !wr_q && (tmr_cnt == TW'(SAMPLE_AT));
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= S_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      we_n_q  <= 1'b1;
      addr_q  <= '0;
      dout_q  <= '0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      st_q    <= st_d;
      if (accept) begin
        row_q <= row_d;
        col_q <= col_d;
        wr_q  <= wr_d;
        wd_q  <= wd_d;
      end
      ras_n_q <= ras_n_d;
      cas_n_q <= cas_n_d;
      we_n_q  <= we_n_d;
      addr_q  <= addr_d;
      dout_q  <= wd_d;
      rv_q    <= rv_d;
      if (rv_d) rd_q <= mem_din;
    end
  end

  assign mem_rowstb_n = ras_n_q;
  assign mem_colstb_n = cas_n_q;
  assign mem_wr_n     = we_n_q;
  assign mem_addr     = addr_q;
  assign mem_dout     = dout_q;
  assign rsp_valid    = rv_q;
  assign rsp_rdata    = rd_q;

  // R3: column strobe only inside a row activation
  p_colstb_in_row_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mem_colstb_n |-> !mem_rowstb_n);

  // R4: write enable leads the column strobe fall
  p_wr_lead_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($fell(mem_colstb_n) && !mem_wr_n) |-> ($past(mem_wr_n) == 1'b0));

  // R4: write enable steady while the column strobe is low
  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!mem_colstb_n && ($past(mem_colstb_n) == 1'b0)) |-> $stable(mem_wr_n));

  // R5: read valid is a single-cycle pulse
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |=> !rsp_valid);

  // R11: no request is taken while a refresh waits
  p_ref_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    ref_pend |-> !req_ready);

endmodule

// File: tb/tb_dram_strobe_ctrl.sv
module tb_dram_strobe_ctrl;

  localparam int P_RAH  = 2;
  localparam int P_CAS  = 4;
  localparam int P_CAC  = 3;
  localparam int P_CP   = 2;
  localparam int P_RP   = 3;
  localparam int P_RMIN = 6;
  localparam int P_RMAX = 40;
  localparam int P_REFI = 60;
  localparam int P_CLOSE = P_RMAX - P_CAS - P_CP - 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic        req_wdata = 1'b0;
  logic        rsp_valid;
  logic        rsp_rdata;
  logic        mem_rowstb_n, mem_colstb_n, mem_wr_n;
  logic [6:0]  mem_addr;
  logic        mem_dout;
  logic        mem_din;

  always #4 clk = ~clk;

  dram_strobe_ctrl #(
    .T_RAH(P_RAH), .T_CAS(P_CAS), .T_CAC(P_CAC), .T_CP(P_CP), .T_RP(P_RP),
    .T_RAS_MIN(P_RMIN), .T_RAS_MAX(P_RMAX), .T_REFI(P_REFI)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_rowstb_n(mem_rowstb_n), .mem_colstb_n(mem_colstb_n), .mem_wr_n(mem_wr_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // memory model and strobe timing monitor
  logic       model [int];
  logic       din_r = 1'b0;
  logic       prev_r = 1'b1, prev_c = 1'b1, prev_w = 1'b1;
  logic [6:0] act_row = '0;
  bit         in_act_cas = 1'b0, have_hi = 1'b0, have_ref = 1'b0;
  bit         rows_seen [128];
  int lo_run = 0, hi_run = 0, rcd = 0, c_hi = 1000, max_lo = 0, last_ref = 0;
  int ras_falls = 0, page_hits = 0, ref_cnt = 0, wraps = 0;
  int v_rp = 0, v_rmax = 0, v_rmin = 0, v_rcd = 0, v_cp = 0, v_noras = 0, v_early = 0, v_refseq = 0;

  assign mem_din = din_r;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_r = 1'b1; prev_c = 1'b1; prev_w = 1'b1; din_r = 1'b0;
    end else begin
      if (!mem_rowstb_n) begin
        if (prev_r) begin
          ras_falls++;
          if (have_hi && hi_run < P_RP) v_rp++;
          lo_run = 1; rcd = 0; in_act_cas = 1'b0; act_row = mem_addr;
        end else begin
          lo_run++; rcd++;
        end
      end else begin
        if (!prev_r) begin
          if (lo_run > P_RMAX) v_rmax++;
          if (lo_run < P_RMIN) v_rmin++;
          if (lo_run > max_lo) max_lo = lo_run;
          if (!in_act_cas) begin
            if (have_ref && int'(act_row) != ((last_ref + 1) % 128)) v_refseq++;
            if (have_ref && last_ref == 127 && act_row == 7'd0) wraps++;
            rows_seen[act_row] = 1'b1;
            last_ref = int'(act_row);
            have_ref = 1'b1;
            ref_cnt++;
          end
          hi_run = 1; have_hi = 1'b1;
        end else hi_run++;
      end
      if (!mem_colstb_n && prev_c) begin
        if (mem_rowstb_n) v_noras++;
        if (!in_act_cas) begin
          if (rcd != P_RAH + 1) v_rcd++;
        end else begin
          page_hits++;
          if (c_hi < P_CP) v_cp++;
        end
        in_act_cas = 1'b1;
        if (!mem_wr_n) begin
          if (prev_w) v_early++;
          model[int'({act_row, mem_addr})] = mem_dout;
          din_r = 1'b0;
        end else begin
          din_r = model.exists(int'({act_row, mem_addr})) ? model[int'({act_row, mem_addr})] : 1'b0;
        end
      end else if (!mem_colstb_n && (mem_wr_n != prev_w)) v_early++;
      if (mem_colstb_n) begin c_hi++; din_r = 1'b0; end
      else c_hi = 0;
      prev_r = mem_rowstb_n; prev_c = mem_colstb_n; prev_w = mem_wr_n;
    end
  end

  task automatic do_req(input bit wr, input logic [13:0] a, input logic d, output logic rd, output bit got);
    rd  = 1'b0;
    got = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      for (int i = 0; i < 60; i++) begin
        if (rsp_valid) begin
          rd = rsp_rdata; got = 1'b1;
          break;
        end
        @(negedge clk);
      end
      @(negedge clk);
      chk(!rsp_valid, "R5", "valid pulse longer than one cycle", int'(rsp_valid), 0);
    end
  endtask

  // {write, row, column, write data, expected read data}
  localparam logic [16:0] VEC [15] = '{
    {1'b1, 7'd5,   7'd1,   1'b1, 1'b0},
    {1'b1, 7'd5,   7'd2,   1'b0, 1'b0},
    {1'b1, 7'd5,   7'd3,   1'b1, 1'b0},
    {1'b1, 7'd9,   7'd1,   1'b1, 1'b0},
    {1'b1, 7'd5,   7'd4,   1'b0, 1'b0},
    {1'b1, 7'd127, 7'd127, 1'b1, 1'b0},
    {1'b1, 7'd0,   7'd0,   1'b1, 1'b0},
    {1'b0, 7'd5,   7'd1,   1'b0, 1'b1},
    {1'b0, 7'd5,   7'd2,   1'b0, 1'b0},
    {1'b0, 7'd5,   7'd3,   1'b0, 1'b1},
    {1'b0, 7'd9,   7'd1,   1'b0, 1'b1},
    {1'b0, 7'd127, 7'd127, 1'b0, 1'b1},
    {1'b0, 7'd0,   7'd0,   1'b0, 1'b1},
    {1'b0, 7'd5,   7'd4,   1'b0, 1'b0},
    {1'b0, 7'd3,   7'd3,   1'b0, 1'b0}
  };

  initial begin
    logic rd;
    bit   got;
    int   f0, h0, r0, bad, seen;

    repeat (3) @(negedge clk);
    chk(mem_rowstb_n == 1'b1, "R1", "row strobe in reset", int'(mem_rowstb_n), 1);
    chk(mem_colstb_n == 1'b1, "R1", "column strobe in reset", int'(mem_colstb_n), 1);
    chk(mem_wr_n == 1'b1, "R1", "write enable in reset", int'(mem_wr_n), 1);
    chk(rsp_valid == 1'b0, "R1", "read valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_colstb_n == 1'b1 && mem_wr_n == 1'b1, "R1", "strobes after reset", int'(mem_colstb_n & mem_wr_n), 1);

    // table walk: writes, then reads covering page hits and row misses
    for (int i = 0; i < 15; i++) begin
      do_req(VEC[i][16], VEC[i][15:2], VEC[i][1], rd, got);
      if (!VEC[i][16]) begin
        chk(got, "R5", "read response missing", int'(got), 1);
        chk(rd == VEC[i][0], "R2", $sformatf("read data row %0d col %0d", VEC[i][15:9], VEC[i][8:2]),
            int'(rd), int'(VEC[i][0]));
      end
    end

    // R6: same-row burst right after a refresh uses one row activation
    repeat (80) @(negedge clk);
    r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk);
    f0 = ras_falls; h0 = page_hits;
    for (int i = 0; i < 3; i++) do_req(1'b0, {7'd5, 7'(i + 1)}, 1'b0, rd, got);
    chk(ras_falls - f0 == 1, "R6", "row activations in same-row burst", ras_falls - f0, 1);
    chk(page_hits - h0 == 2, "R6", "page-mode column cycles", page_hits - h0, 2);

    // R11: long gap-free same-row stream crosses refresh ticks
    r0 = ref_cnt; bad = 0;
    for (int i = 0; i < 30; i++) begin
      do_req(1'b0, {7'd5, 7'((i % 3) + 1)}, 1'b0, rd, got);
      if (!got || rd != ((i % 3) != 1)) bad++;
    end
    chk(bad == 0, "R11", "stream data errors", bad, 0);
    chk(ref_cnt - r0 >= 2, "R11", "refreshes inside stream", ref_cnt - r0, 2);

    // R9 / R10: idle window covering more than 128 intervals
    foreach (rows_seen[k]) rows_seen[k] = 1'b0;
    r0 = ref_cnt;
    repeat (7880) @(negedge clk);
    seen = 0;
    foreach (rows_seen[k]) if (rows_seen[k]) seen++;
    chk(ref_cnt - r0 >= 7880 / P_REFI - 1 && ref_cnt - r0 <= 7880 / P_REFI + 1,
        "R9", "refresh count in window", ref_cnt - r0, 7880 / P_REFI);
    chk(seen == 128, "R10", "distinct rows refreshed", seen, 128);
    chk(wraps >= 1, "R10", "row counter wrap 127 to 0", wraps, 1);
    chk(v_refseq == 0, "R10", "refresh row order breaks", v_refseq, 0);

    // timing summaries from the monitor
    chk(v_rcd == 0, "R3", "row-to-column delay violations", v_rcd, 0);
    chk(v_noras == 0, "R3", "column strobe without row", v_noras, 0);
    chk(v_early == 0, "R4", "early-write violations", v_early, 0);
    chk(v_cp == 0, "R6", "column precharge violations", v_cp, 0);
    chk(v_rp == 0, "R7", "row precharge violations", v_rp, 0);
    chk(v_rmax == 0, "R8", "row strobe over maximum", v_rmax, 0);
    chk(v_rmin == 0, "R8", "row strobe under minimum", v_rmin, 0);
    chk(max_lo > P_CLOSE && max_lo <= P_RMAX, "R8", "longest row activation", max_lo, P_CLOSE + 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule